// File: doc/BRIEF.md
# Accumulator Bit-Field Extractor

This block takes a variable-length bit field out of a 64-bit accumulator and returns it right-aligned and zero-extended in a 32-bit word. A 6-bit position field held in a 32-bit control word gives the highest bit of the field. A 5-bit size operand gives the field width minus one, so widths run from 1 to 32 bits.

The block writes the outcome back into the control word it returns. A dedicated flag bit is cleared when the field fits below the position and set when it does not. An optional decrement mode moves the position field down past the bits just consumed, so that a stream of fields can be read out of the accumulator one request after another.

Every request is presented for one cycle with a valid strobe. The result, the updated control word and an output valid appear one clock later and stay steady until the next strobe.

Top module: `acc_field_extract`

## Requirements
- R1: The position is control bits 5:0 and the width is size+1. A request succeeds when position+1 >= size+1, which is the same as position >= size, and fails otherwise.
- R2: On success, the result holds accumulator bits position down to position-size in its low size+1 bits, and every result bit above the field is zero.
- R3: On success, control bit 14 of the returned control word is 0.
- R4: On failure, the result is 0 and control bit 14 of the returned control word is 1.
- R5: On failure, the position field of the returned control word equals the incoming one, whether decrement mode is on or off.
- R6: Control bits 31:15 and 13:6 of the returned control word equal the incoming ones.
- R7: With decrement mode off, the position field of the returned control word equals the incoming one.
- R8: With decrement mode on and success with position > size, the returned position field is position-size-1.
- R9: With decrement mode on and success with position == size, the returned position field wraps to 63.
- R10: Results and out_valid appear one clock after a request strobe. In a cycle without a strobe, out_valid is 0 and the result and control outputs keep their values. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| acc_in | input | 64 | Accumulator value |
| size_in | input | 5 | Field width minus one |
| dec_mode | input | 1 | Decrement the position after a successful extraction |
| ctrl_in | input | 32 | Current control word; bits 5:0 give the position |
| field_out | output | 32 | Extracted field, zero-extended |
| ctrl_out | output | 32 | Updated control word |
| out_valid | output | 1 | The result registers were loaded on the previous edge |

## Verification
Each result is due exactly one clock edge after its strobe: the field, the flag bit, the new position and out_valid all come from one register stage. The reference model in the bench updates its expected values on the same edge that registers the request. It compares them with the outputs on the following falling edge, so every comparison falls halfway between the loading edge and the next one. Idle cycles between requests are compared in the same way, which checks that the outputs hold their values and that out_valid drops.

// File: rtl/acc_xtr_pkg.sv
package acc_xtr_pkg;
    localparam int ACC_W    = 64;
    localparam int OUT_W    = 32;
    localparam int CTRL_W   = 32;
    localparam int POS_W    = $clog2(ACC_W);
    localparam int SIZE_W   = $clog2(OUT_W);
    localparam int FAIL_BIT = 14;

    typedef struct packed {
        logic              vld;
        logic [OUT_W-1:0]  field;
        logic [CTRL_W-1:0] ctrl;
    } xtr_state_t;
endpackage

// File: rtl/acc_xtr_window.sv
module acc_xtr_window #(
    parameter int ACC_W  = 64,
    parameter int OUT_W  = 32,
    parameter int POS_W  = $clog2(ACC_W),
    parameter int SIZE_W = $clog2(OUT_W)
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [POS_W-1:0]  pos,
    input  logic [SIZE_W-1:0] size,
    output logic              fits,
    output logic [OUT_W-1:0]  field
);
    logic [POS_W-1:0] size_ext;
    logic [POS_W-1:0] low_bit;
    logic [ACC_W-1:0] shifted;
    logic [OUT_W-1:0] keep;

    always_comb begin
        size_ext = POS_W'(size);
        fits     = (pos >= size_ext);
        low_bit  = pos - size_ext;
        shifted  = acc >> low_bit;
    end

    for (genvar i = 0; i < OUT_W; i++) begin : g_keep
        assign keep[i] = (i <= int'(size));
    end

    assign field = fits ? (shifted[OUT_W-1:0] & keep) : '0;
endmodule

// File: rtl/acc_xtr_ctrl_upd.sv
module acc_xtr_ctrl_upd #(
    parameter int CTRL_W   = 32,
    parameter int POS_W    = 6,
    parameter int SIZE_W   = 5,
    parameter int FAIL_BIT = 14
) (
    input  logic [CTRL_W-1:0] ctrl_cur,
    input  logic [SIZE_W-1:0] size,
    input  logic              fits,
    input  logic              dec,
    output logic [CTRL_W-1:0] ctrl_nxt
);
    logic [POS_W-1:0] pos_cur;
    logic [POS_W-1:0] pos_dec;

    always_comb begin
        pos_cur = ctrl_cur[POS_W-1:0];
        // modulo 2**POS_W: a result of -1 lands on the all-ones position
        pos_dec = pos_cur - POS_W'(size) - POS_W'(1);
        ctrl_nxt = ctrl_cur;
        ctrl_nxt[FAIL_BIT] = ~fits;
        if (fits && dec) begin
            ctrl_nxt[POS_W-1:0] = pos_dec;
        end
    end
endmodule

// File: rtl/acc_field_extract.sv
module acc_field_extract
    import acc_xtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [63:0]       acc_in,
    input  logic [4:0]        size_in,
    input  logic              dec_mode,
    input  logic [31:0]       ctrl_in,
    output logic [31:0]       field_out,
    output logic [31:0]       ctrl_out,
    output logic              out_valid
);
    logic              fits;
    logic [OUT_W-1:0]  field_w;
    logic [CTRL_W-1:0] ctrl_w;
    xtr_state_t        st_d, st_q;

    acc_xtr_window #(
        .ACC_W(ACC_W), .OUT_W(OUT_W), .POS_W(POS_W), .SIZE_W(SIZE_W)
    ) u_window (
        .acc   (acc_in),
        .pos   (ctrl_in[POS_W-1:0]),
        .size  (size_in),
        .fits  (fits),
        .field (field_w)
    );

    acc_xtr_ctrl_upd #(
        .CTRL_W(CTRL_W), .POS_W(POS_W), .SIZE_W(SIZE_W), .FAIL_BIT(FAIL_BIT)
    ) u_ctrl (
        .ctrl_cur (ctrl_in),
        .size     (size_in),
        .fits     (fits),
        .dec      (dec_mode),
        .ctrl_nxt (ctrl_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.field = field_w;
            st_d.ctrl  = ctrl_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign field_out = st_q.field;
    assign ctrl_out  = st_q.ctrl;
    assign out_valid = st_q.vld;

    assert_fail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ctrl_out[FAIL_BIT]) |-> (field_out == '0));

    assert_fail_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ctrl_out[FAIL_BIT]) |-> (ctrl_out[POS_W-1:0] == $past(ctrl_in[POS_W-1:0])));

    assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ctrl_out[CTRL_W-1:FAIL_BIT+1] == $past(ctrl_in[CTRL_W-1:FAIL_BIT+1])
                    && ctrl_out[FAIL_BIT-1:POS_W] == $past(ctrl_in[FAIL_BIT-1:POS_W])));

    assert_nodec_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(dec_mode)) |-> (ctrl_out[POS_W-1:0] == $past(ctrl_in[POS_W-1:0])));

    assert_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ctrl_out[FAIL_BIT] == ($past(ctrl_in[POS_W-1:0]) < POS_W'($past(size_in)))));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(field_out) && $stable(ctrl_out)));
endmodule

// File: tb/acc_field_extract_bench.sv
module acc_field_extract_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] acc_in = '0;
    logic [4:0]  size_in = '0;
    logic        dec_mode = 1'b0;
    logic [31:0] ctrl_in = '0;
    logic [31:0] field_out;
    logic [31:0] ctrl_out;
    logic        out_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit started  = 1'b0;
    bit finished = 1'b0;

    logic [31:0] exp_field = '0;
    logic [31:0] exp_ctrl  = '0;
    logic        exp_vld   = 1'b0;
    string       tag_field = "R10";
    string       tag_pos   = "R10";
    string       tag_flag  = "R10";

    always #5 clk = ~clk;

    acc_field_extract u_acc_field_extract (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_in(acc_in),
        .size_in(size_in), .dec_mode(dec_mode), .ctrl_in(ctrl_in),
        .field_out(field_out), .ctrl_out(ctrl_out), .out_valid(out_valid)
    );

    // Reference model: behavioural, updated on each rising edge
    always @(posedge clk) begin
        int pos, w, np;
        logic [63:0] m;
        started <= 1'b1;
        if (!rst_n) begin
            exp_field <= '0; exp_ctrl <= '0; exp_vld <= 1'b0;
            tag_field <= "R10"; tag_pos <= "R10"; tag_flag <= "R10";
        end else if (req_valid) begin
            pos = int'(ctrl_in[5:0]);
            w   = int'(size_in) + 1;
            exp_vld <= 1'b1;
            if (pos + 1 >= w) begin
                m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
                exp_field <= 32'((acc_in >> (pos - w + 1)) & m);
                tag_field <= "R1 R2";
                tag_flag  <= "R3";
                np = pos;
                if (dec_mode) begin
                    np = pos - w;
                    if (np < 0) begin np = 63; tag_pos <= "R9"; end
                    else tag_pos <= "R8";
                end else tag_pos <= "R7";
                exp_ctrl <= {ctrl_in[31:15], 1'b0, ctrl_in[13:6], 6'(np)};
            end else begin
                exp_field <= '0;
                exp_ctrl  <= {ctrl_in[31:15], 1'b1, ctrl_in[13:0]};
                tag_field <= "R1 R4"; tag_flag <= "R4"; tag_pos <= "R5";
            end
        end else begin
            exp_vld <= 1'b0;
            tag_field <= "R10"; tag_pos <= "R10"; tag_flag <= "R10";
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Compare on every falling edge, half a period after the loading edge
    always @(negedge clk) begin
        if (started && !finished) begin
            check("R10 valid", 64'(out_valid), 64'(exp_vld));
            check(tag_field, 64'(field_out), 64'(exp_field));
            check(tag_flag, 64'(ctrl_out[14]), 64'(exp_ctrl[14]));
            check(tag_pos, 64'(ctrl_out[5:0]), 64'(exp_ctrl[5:0]));
            check("R6 passthru", 64'({ctrl_out[31:15], ctrl_out[13:6]}),
                                 64'({exp_ctrl[31:15], exp_ctrl[13:6]}));
        end
    end

    task automatic req(input logic [63:0] a, input logic [4:0] s, input logic d, input logic [31:0] c);
        @(negedge clk);
        req_valid = 1'b1; acc_in = a; size_in = s; dec_mode = d; ctrl_in = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; acc_in = {$urandom, $urandom}; ctrl_in = $urandom;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        // R1 R2: widest field at the top of the accumulator
        req(64'hDEAD_BEEF_0123_4567, 5'd31, 1'b0, 32'hA5A5_003F);
        // R9: position equals size, decrement wraps to 63
        req(64'h0000_0000_0000_002B, 5'd5, 1'b1, 32'h0000_0005);
        // R4 R5: position one below size fails, decrement ignored
        req(64'hFFFF_FFFF_FFFF_FFFF, 5'd5, 1'b1, 32'hFFFF_BFC4);
        // R9: single bit at position 0
        req(64'h0000_0000_0000_0001, 5'd0, 1'b1, 32'h1234_4000);
        // R8: ordinary decrement
        req(64'h00AB_CD00_0000_0000, 5'd7, 1'b1, 32'h0000_0028);
        idle(2);
        // R7 R3: stale fail flag is cleared, position kept
        req(64'h8000_0000_0000_0000, 5'd0, 1'b0, 32'hFFFF_FFFF);
        // R4: size 31 with position 30
        req(64'h7777_7777_7777_7777, 5'd31, 1'b0, 32'h0000_001E);
        idle(1);
        // sequential stream walking down with decrement
        req(64'hFEDC_BA98_7654_3210, 5'd3, 1'b1, 32'h0000_003F);
        req(64'hFEDC_BA98_7654_3210, 5'd3, 1'b1, 32'h0000_003B);
        for (int k = 0; k < 300; k++) begin
            if (($urandom & 3) == 0) idle(1);
            else req({$urandom, $urandom}, 5'($urandom), 1'($urandom), $urandom);
        end
        idle(3);
        finish_run();
    end

    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule